// File: doc/BRIEF.md
# Scan Self-Test Sequencer

This block runs a pseudo-random scan self-test on a scan-inserted logic core when given nothing more than a clock and a test-mode level. While test mode is high it takes control of the core's reset, the scan-enable line and the input multiplexers. It drives the advance enable of an external pattern generator and the enable of an external signature compactor. For each pattern it holds scan enable for the length of the longest chain, then drops it for a single capture cycle. The first few patterns run with the core held in reset. The remaining patterns run with reset released.

After the programmed number of patterns, the sequencer shifts one more chain length to unload the last capture into the compactor. It then issues a one-cycle compare strobe and latches the compactor's match flag as a single pass/fail result. Done and the result are held until test mode falls. Dropping test mode at any point returns the block to idle on the next clock and hands every path back to functional use.

The pattern generator, the compactor and the core are outside this block. The compactor's compare result reaches the sequencer through `sig_match`.

Top module: `lbist_ctrl`

## Requirements
- R1: Every pattern load holds `scan_enable` high for exactly `CHAIN_LEN` consecutive cycles.
- R2: Each load is followed by exactly one capture cycle in which `scan_enable`, `lfsr_adv` and `misr_en` are all low. The next load starts on the following cycle.
- R3: `dut_rst` is high through the shift and capture cycles of patterns 0 to `RESET_PATS`-1. It is low for every later pattern, and it is low whenever the block is idle, flushing, comparing or done.
- R4: `in_mux_sel` equals `test_mode` in the same cycle, with no register in the path.
- R5: `lfsr_adv` is high only in load-shift cycles. It is low in capture, flush, compare and done cycles, giving `NUM_PATS`×`CHAIN_LEN` advances per run.
- R6: `misr_en` is high in the shift cycles of every pattern except pattern 0, whose unload carries no captured data. It is also high in every flush cycle, and it is low in all other cycles.
- R7: After the capture of pattern `NUM_PATS`-1 there are `CHAIN_LEN` flush cycles with `scan_enable` high. These are followed by one cycle with `sig_cmp` high and then `done` high.
- R8: `pass` is high in the done state exactly when `sig_match` was high during the `sig_cmp` cycle.
- R9: While `test_mode` stays high after completion, `done` stays high, `pass` keeps its value regardless of `sig_match`, and no new run starts.
- R10: When `test_mode` is low at a clock edge, the block is idle in the next cycle with every registered output low. A later rise of `test_mode` starts a fresh run beginning with the reset phase.
- R11: After a synchronous reset with `rst_n` low and `test_mode` low, every output is low.
- R12: With `test_mode` high at a clock edge while idle, the first load-shift cycle begins in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| test_mode | input | 1 | Level that requests and holds a self-test run |
| sig_match | input | 1 | Compactor signature equals the expected value |
| scan_enable | output | 1 | Scan-enable to all chains (high = shift) |
| dut_rst | output | 1 | Reset to the core, active high |
| in_mux_sel | output | 1 | Selects test paths on the core's input muxes |
| lfsr_adv | output | 1 | Advance enable for the pattern generator |
| misr_en | output | 1 | Compaction enable for the signature register |
| sig_cmp | output | 1 | One-cycle strobe to compare the signature |
| done | output | 1 | Run complete |
| pass | output | 1 | Result of the compare, valid while done |

## Verification
The bench runs complete self-tests with the compactor reporting a match and with it reporting a mismatch. Identical sequencing in both runs combined with opposite results shows that the verdict comes only from the compare-cycle sample. Every cycle of a run is checked against a schedule built from the chain length and the pattern counts. This separates an off-by-one shift count, a missing or doubled capture, a reset phase of the wrong length, and compactor enables on the first unload or during capture. A run aborted part-way and then restarted shows that the return to idle is immediate and that the restarted run begins with the reset phase. Toggling `sig_match` after completion shows that the held result ignores it.

// File: rtl/lbist_pkg.sv
// Package: shared types for the scan self-test sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package lbist_pkg;

    // Sequencer phases.
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_RST_SHIFT = 3'd1,
        ST_RST_CAP   = 3'd2,
        ST_SHIFT     = 3'd3,
        ST_CAP       = 3'd4,
        ST_FLUSH     = 3'd5,
        ST_COMPARE   = 3'd6,
        ST_DONE      = 3'd7
    } lbist_state_e;

endpackage

// File: rtl/lbist_shift_cnt.sv
// Module: lbist_shift_cnt
// Counts the cycles of one chain length. It flags the last cycle so the
// sequencer can leave a shift or flush phase on time.
// Assumes: LIMIT >= 1. When en is low the count returns to zero.
module lbist_shift_cnt #(
    parameter int LIMIT = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic last
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] TOP = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    // Cycle counter: counts while enabled, wraps on the last cycle, clears when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt_q <= '0;
        else if (cnt_q == TOP) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
    end

    assign last = en && (cnt_q == TOP);
endmodule

// File: rtl/lbist_pat_cnt.sv
// Module: lbist_pat_cnt
// Counts patterns that have been captured. It reports whether the current
// pattern is the first one, whether it is the last one, and whether the
// next pattern still belongs to the reset-held phase.
// Assumes: TOTAL >= 1. clr has priority over inc.
module lbist_pat_cnt #(
    parameter int TOTAL     = 8000,
    parameter int RST_PATS  = 4,
    localparam int W        = $clog2(TOTAL + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         first,
    output logic         last,
    output logic         rst_next
);
    logic [W-1:0] cnt_q;
    logic [31:0]  next_idx;

    // Pattern counter: increments once per capture, cleared while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= '0;
        else if (inc) cnt_q <= cnt_q + 1'b1;
    end

    // Index the following pattern will have, widened for comparison.
    always_comb next_idx = 32'(cnt_q) + 32'd1;

    assign cnt      = cnt_q;
    assign first    = (cnt_q == '0);
    assign last     = (32'(cnt_q) == 32'(TOTAL - 1));
    assign rst_next = (next_idx < 32'(RST_PATS));
endmodule

// File: rtl/lbist_seq_fsm.sv
// Module: lbist_seq_fsm
// Phase sequencer: reset-held patterns, free patterns, the unload flush,
// the compare and done. It returns to idle whenever test_mode is low.
// Assumes: shift_last comes from a counter enabled in the shift and flush phases.
module lbist_seq_fsm
    import lbist_pkg::*;
#(
    parameter int RESET_PATS = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         test_mode,
    input  logic         shift_last,
    input  logic         pat_last,
    input  logic         rst_next,
    output lbist_state_e state
);
    lbist_state_e state_q, state_d;

    // Next-phase selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      state_d = (RESET_PATS > 0) ? ST_RST_SHIFT : ST_SHIFT;
            ST_RST_SHIFT: if (shift_last) state_d = ST_RST_CAP;
            ST_SHIFT:     if (shift_last) state_d = ST_CAP;
            ST_RST_CAP,
            ST_CAP:       state_d = pat_last ? ST_FLUSH :
                                    (rst_next ? ST_RST_SHIFT : ST_SHIFT);
            ST_FLUSH:     if (shift_last) state_d = ST_COMPARE;
            ST_COMPARE:   state_d = ST_DONE;
            ST_DONE:      state_d = ST_DONE;
            default:      state_d = ST_IDLE;
        endcase
        if (!test_mode) state_d = ST_IDLE;
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign state = state_q;
endmodule

// File: rtl/lbist_ctrl.sv
// Module: lbist_ctrl (top)
// Scan self-test sequencer. It owns the core's reset, the scan enable, the
// input muxes and the generator and compactor enables while test_mode is high.
// Assumes: sig_match is valid in the cycle sig_cmp is high.
module lbist_ctrl
    import lbist_pkg::*;
#(
    parameter int CHAIN_LEN  = 30,
    parameter int RESET_PATS = 4,
    parameter int NUM_PATS   = 8000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic test_mode,
    input  logic sig_match,
    output logic scan_enable,
    output logic dut_rst,
    output logic in_mux_sel,
    output logic lfsr_adv,
    output logic misr_en,
    output logic sig_cmp,
    output logic done,
    output logic pass
);
    localparam int PCW = $clog2(NUM_PATS + 1);

    lbist_state_e state_q;
    logic         shift_phase, load_phase, cap_phase;
    logic         shift_last, pat_first, pat_last, rst_next;
    logic [PCW-1:0] pat_cnt;
    logic         pass_q;

    // Phase decode.
    always_comb begin
        load_phase  = (state_q == ST_RST_SHIFT) || (state_q == ST_SHIFT);
        cap_phase   = (state_q == ST_RST_CAP)   || (state_q == ST_CAP);
        shift_phase = load_phase || (state_q == ST_FLUSH);
    end

    lbist_shift_cnt #(.LIMIT(CHAIN_LEN)) u_shift_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (shift_phase),
        .last  (shift_last)
    );

    lbist_pat_cnt #(.TOTAL(NUM_PATS), .RST_PATS(RESET_PATS)) u_pat_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (state_q == ST_IDLE),
        .inc      (cap_phase),
        .cnt      (pat_cnt),
        .first    (pat_first),
        .last     (pat_last),
        .rst_next (rst_next)
    );

    lbist_seq_fsm #(.RESET_PATS(RESET_PATS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .test_mode  (test_mode),
        .shift_last (shift_last),
        .pat_last   (pat_last),
        .rst_next   (rst_next),
        .state      (state_q)
    );

    // Verdict latch: samples the compactor match on the compare strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == ST_IDLE) pass_q <= 1'b0;
        else if (state_q == ST_COMPARE)   pass_q <= sig_match;
    end

    // Output drive.
    always_comb begin
        scan_enable = shift_phase;
        dut_rst     = (state_q == ST_RST_SHIFT) || (state_q == ST_RST_CAP);
        in_mux_sel  = test_mode;
        lfsr_adv    = load_phase;
        misr_en     = shift_phase && !pat_first;
        sig_cmp     = (state_q == ST_COMPARE);
        done        = (state_q == ST_DONE);
        pass        = done && pass_q;
    end
endmodule

// File: rtl/lbist_ctrl_chk.sv
// Module: lbist_ctrl_chk
// Protocol checker bound to lbist_ctrl. It watches the outputs and the
// internal phase and pattern count.
// Assumes: bound with the same parameters as the instance it watches.
module lbist_ctrl_chk
    import lbist_pkg::*;
#(
    parameter int CHAIN_LEN  = 30,
    parameter int RESET_PATS = 4,
    parameter int NUM_PATS   = 8000,
    localparam int PCW       = $clog2(NUM_PATS + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           test_mode,
    input logic           scan_enable,
    input logic           dut_rst,
    input logic           lfsr_adv,
    input logic           misr_en,
    input logic           done,
    input logic           pass,
    input lbist_state_e   state_q,
    input logic [PCW-1:0] pat_cnt
);
    int run_q;

    // Length of the current run of scan-enable cycles under test mode.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 0;
        else if (scan_enable && test_mode) run_q <= run_q + 1;
        else run_q <= 0;
    end

    assert_shift_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && $past(test_mode) && $fell(scan_enable)) |-> (run_q == CHAIN_LEN));

    assert_one_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_CAP || state_q == ST_RST_CAP) && test_mode) |=> scan_enable);

    assert_reset_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dut_rst |-> (32'(pat_cnt) < 32'(RESET_PATS)));

    assert_adv_in_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_adv |-> (scan_enable && state_q != ST_FLUSH));

    assert_no_first_unload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        misr_en |-> (pat_cnt != '0));

    assert_hold_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && test_mode) |=> (done && $stable(pass)));

    assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |=> (state_q == ST_IDLE));
endmodule

bind lbist_ctrl lbist_ctrl_chk #(
    .CHAIN_LEN  (CHAIN_LEN),
    .RESET_PATS (RESET_PATS),
    .NUM_PATS   (NUM_PATS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .test_mode   (test_mode),
    .scan_enable (scan_enable),
    .dut_rst     (dut_rst),
    .lfsr_adv    (lfsr_adv),
    .misr_en     (misr_en),
    .done        (done),
    .pass        (pass),
    .state_q     (state_q),
    .pat_cnt     (pat_cnt)
);

// File: tb/lbist_ctrl_tb.sv
// Directed bench for lbist_ctrl; one task per scenario.
module lbist_ctrl_tb;
    localparam int CL = 5;
    localparam int RP = 2;
    localparam int NP = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic test_mode = 1'b0;
    logic sig_match = 1'b0;
    logic scan_enable, dut_rst, in_mux_sel, lfsr_adv, misr_en, sig_cmp, done, pass;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    lbist_ctrl #(.CHAIN_LEN(CL), .RESET_PATS(RP), .NUM_PATS(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .sig_match(sig_match),
        .scan_enable(scan_enable), .dut_rst(dut_rst), .in_mux_sel(in_mux_sel),
        .lfsr_adv(lfsr_adv), .misr_en(misr_en), .sig_cmp(sig_cmp),
        .done(done), .pass(pass)
    );

    // Compare one value and report a mismatch.
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
        end
    endtask

    // Output vector {scan_enable, dut_rst, lfsr_adv, misr_en, sig_cmp, done}.
    function automatic logic [5:0] outs();
        return {scan_enable, dut_rst, lfsr_adv, misr_en, sig_cmp, done};
    endfunction

    // R11: reset state.
    task automatic t_reset();
        rst_n = 1'b0;
        test_mode = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 outputs after reset", {26'd0, outs()}, 32'd0);
        chk("R11 pass after reset", 32'(pass), 32'd0);
        chk("R4 mux low with test_mode low", 32'(in_mux_sel), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 idle after release", {26'd0, outs()}, 32'd0);
    endtask

    // R12 R1 R2 R3 R5 R6 R7 R8: full run walked cycle by cycle.
    task automatic t_full_run(input logic match);
        sig_match = match;
        test_mode = 1'b1;
        #1;
        chk("R4 mux follows test_mode", 32'(in_mux_sel), 32'd1);
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            for (int s = 0; s < CL; s++) begin
                chk("R12 R1 R3 R5 R6 shift cycle", {26'd0, outs()},
                    {26'd0, 1'b1, 1'(p < RP), 1'b1, 1'(p > 0), 1'b0, 1'b0});
                @(negedge clk);
            end
            chk("R2 R3 R5 R6 capture cycle", {26'd0, outs()},
                {26'd0, 1'b0, 1'(p < RP), 1'b0, 1'b0, 1'b0, 1'b0});
            @(negedge clk);
        end
        for (int s = 0; s < CL; s++) begin
            chk("R7 R6 flush cycle", {26'd0, outs()}, {26'd0, 6'b100100});
            @(negedge clk);
        end
        chk("R7 compare strobe", {26'd0, outs()}, {26'd0, 6'b000010});
        @(negedge clk);
        chk("R7 done", {26'd0, outs()}, {26'd0, 6'b000001});
        chk("R8 verdict", 32'(pass), 32'(match));
    endtask

    // R9: hold after completion, then R10 release.
    task automatic t_hold_and_release();
        logic held;
        held = pass;
        sig_match = ~sig_match;
        repeat (10) @(negedge clk);
        chk("R9 done held", 32'(done), 32'd1);
        chk("R9 pass held", 32'(pass), 32'(held));
        chk("R9 no restart", 32'({scan_enable, dut_rst, lfsr_adv}), 32'd0);
        test_mode = 1'b0;
        #1;
        chk("R4 mux drops with test_mode", 32'(in_mux_sel), 32'd0);
        @(negedge clk);
        chk("R10 idle after release", {26'd0, outs()}, 32'd0);
        chk("R10 pass cleared", 32'(pass), 32'd0);
    endtask

    // R10: abort part-way through the free patterns, then restart.
    task automatic t_abort_restart();
        sig_match = 1'b1;
        test_mode = 1'b1;
        repeat (RP * (CL + 1) + 3) @(negedge clk);
        chk("R10 mid-run shifting", 32'(scan_enable), 32'd1);
        test_mode = 1'b0;
        @(negedge clk);
        chk("R10 abort to idle", {26'd0, outs()}, 32'd0);
        @(negedge clk);
        t_full_run(1'b1);
        test_mode = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_full_run(1'b1);
        t_hold_and_release();
        t_full_run(1'b0);
        t_hold_and_release();
        t_abort_restart();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule